// File: doc/BRIEF.md
# I2C General-Call Slave Receiver

This block is the receive half of a byte-oriented I2C slave. It watches open-drain SCL and SDA through two-stage synchronizers and detects START and STOP. It recognises either its own 7-bit write address or the general-call address and takes in data bytes one at a time, returning ACK or NACK according to an acknowledge-enable bit that the host controls.

After each bus event the block loads an 8-bit status code, raises an internal service flag and pulls the active-low interrupt line. After a received byte it also holds SCL low until the host clears the flag. A single control write to the block does four things at once. It clears the flag. It chooses whether the next byte is acknowledged or whether the slave leaves the addressed state with or without address recognition. It can queue a START request that is issued when the bus goes idle. It can force the slave back to the unaddressed state.

Host writes use a one-bit select. Select 0 writes the control byte: bit 5 = queue START, bit 4 = abort to unaddressed, bit 3 = service flag (writing 0 clears it, writing 1 leaves it alone), bit 2 = acknowledge enable. Select 1 writes the address byte: bits 7:1 = own address, bit 0 = general-call enable.

Top module: `i2c_gc_slave_rx`

## Requirements
- R1: After reset the status reads F8h, `int_n` is high, neither `scl_low` nor `sda_low` is asserted and `start_issue` is low.
- R2: A first byte equal to the own address with direction bit 0, received while acknowledge enable is 1, is acknowledged by SDA low during the ninth clock and loads status 60h. A first byte with direction bit 1 is not acknowledged and loads nothing.
- R3: The first byte 00h is acknowledged, and loads status 70h, only when general-call enable and acknowledge enable are both 1. Otherwise it is not acknowledged and `int_n` stays high.
- R4: A data byte under the own address is acknowledged and loads 80h when acknowledge enable is 1. It is not acknowledged and loads 88h when acknowledge enable is 0. In both cases the byte appears on `rx_data`.
- R5: A data byte under the general call loads E0h with ACK when acknowledge enable is 1, and E8h with NACK when it is 0.
- R6: After an 88h or E8h status is cleared, the slave is unaddressed. Further data bytes are not acknowledged and load no status, and a following STOP loads no status.
- R7: A STOP or repeated START while addressed as receiver loads A0h, and SCL is not held low for it.
- R8: Each status load drives `int_n` low. After a received byte, SCL is held low until the host clears the service flag. Clearing the flag raises `int_n`, returns the status to F8h and releases SCL.
- R9: A control write with bit 5 set and bit 3 clear queues a START. `start_issue` then pulses for exactly one cycle once no transfer is in progress: at once if the bus is idle, otherwise after the next STOP.
- R10: With acknowledge enable 0, the own address is not recognised.
- R11: A control write with bit 4 set returns the slave to the unaddressed state, so the bytes that follow are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 = control byte, 1 = address byte |
| host_wdata | input | 8 | Host write data |
| status | output | 8 | Status code |
| rx_data | output | 8 | Last received data byte |
| int_n | output | 1 | Active-low interrupt |
| start_issue | output | 1 | One-cycle pulse when a queued START is released |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low | output | 1 | Pull SCL low (open drain) |
| sda_low | output | 1 | Pull SDA low (open drain) |

## Verification
The bench models a wired-AND bus, so the ninth-clock acknowledge and the SCL hold are seen on the line itself. One corner case is the clock hold after a byte. It is checked while the bench master is already releasing SCL, and a design that failed to hold the clock would let the master run past an unread byte. A second is the unaddressed state after a NACK or an abort. A design that kept the slave addressed would acknowledge stray bytes or report A0h on the next STOP. The queued START is checked both during a repeated-START transfer, where an early pulse would collide with the ongoing transfer, and on an idle bus, where a missing pulse would leave the request stuck.

// File: rtl/i2c_gc_slave_rx.sv
module i2c_gc_slave_rx #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] status,
  output logic [7:0] rx_data,
  output logic       int_n,
  output logic       start_issue,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_low,
  output logic       sda_low
);
  localparam logic [7:0] ST_IDLE  = 8'hF8;
  localparam logic [7:0] ST_OWNW  = 8'h60;
  localparam logic [7:0] ST_GCA   = 8'h70;
  localparam logic [7:0] ST_OWN_A = 8'h80;
  localparam logic [7:0] ST_OWN_N = 8'h88;
  localparam logic [7:0] ST_GC_A  = 8'hE0;
  localparam logic [7:0] ST_GC_N  = 8'hE8;
  localparam logic [7:0] ST_END   = 8'hA0;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  logic [SYNC-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s, sda_s;
  st_t st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [6:0] own;
  logic in_ack, ack, gc, gc_en, si, aa, stretch, busy, sta_pend;
  logic unused_bits;

  assign scl_s = scl_q[SYNC-1];
  assign sda_s = sda_q[SYNC-1];
  assign unused_bits = ^{host_wdata[7:6], host_wdata[1:0]};

  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  wire own_hit  = aa && sh[7:1] == own && !sh[0];
  wire gc_hit   = aa && gc_en && sh == 8'h00;
  wire hit      = (st == S_ADDR) ? (own_hit | gc_hit) : aa;

  assign int_n   = ~si;
  assign scl_low = si & stretch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sda_q <= {sda_q[SYNC-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      sh <= '0;
      own <= '0;
      in_ack <= 1'b0;
      ack <= 1'b0;
      gc <= 1'b0;
      gc_en <= 1'b0;
      si <= 1'b0;
      aa <= 1'b0;
      stretch <= 1'b0;
      busy <= 1'b0;
      sta_pend <= 1'b0;
      status <= ST_IDLE;
      rx_data <= '0;
      sda_low <= 1'b0;
      start_issue <= 1'b0;
    end else begin
      start_issue <= 1'b0;
      if (sta_pend && !busy) begin
        sta_pend <= 1'b0;
        start_issue <= 1'b1;
      end
      if (host_we && host_sel) {own, gc_en} <= host_wdata;
      if (host_we && !host_sel) begin
        aa <= host_wdata[2];
        if (!host_wdata[3]) begin
          si <= 1'b0;
          stretch <= 1'b0;
          status <= ST_IDLE;
          if (host_wdata[5]) sta_pend <= 1'b1;
        end
        if (host_wdata[4]) begin
          st <= S_IDLE;
          in_ack <= 1'b0;
          sda_low <= 1'b0;
        end
      end
      if (start_c) begin
        busy <= 1'b1;
        if (st == S_DATA) begin
          status <= ST_END;
          si <= 1'b1;
          stretch <= 1'b0;
        end
        st <= S_ADDR;
        cnt <= '0;
        in_ack <= 1'b0;
        sda_low <= 1'b0;
      end else if (stop_c) begin
        busy <= 1'b0;
        if (st == S_DATA) begin
          status <= ST_END;
          si <= 1'b1;
          stretch <= 1'b0;
        end
        st <= S_IDLE;
        in_ack <= 1'b0;
        sda_low <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise && !in_ack && cnt != 4'd8) begin
          sh <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end
        if (scl_fall && cnt == 4'd8) begin
          if (!in_ack) begin
            in_ack <= 1'b1;
            ack <= hit;
            sda_low <= hit;
            if (st == S_ADDR) gc <= gc_hit & ~own_hit;
          end else begin
            in_ack <= 1'b0;
            sda_low <= 1'b0;
            cnt <= '0;
            if (st == S_ADDR) begin
              if (ack) begin
                st <= S_DATA;
                si <= 1'b1;
                stretch <= 1'b1;
                status <= gc ? ST_GCA : ST_OWNW;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              rx_data <= sh;
              si <= 1'b1;
              stretch <= 1'b1;
              status <= gc ? (ack ? ST_GC_A : ST_GC_N) : (ack ? ST_OWN_A : ST_OWN_N);
              if (!ack) st <= S_IDLE;
            end
          end
        end
      end
    end
  end

  p_f8_when_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int_n |-> status == ST_IDLE);
  p_sda_only_in_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low |-> in_ack);
  p_rx_with_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> !int_n);
  p_end_no_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status == ST_END |-> !scl_low);
  p_irq_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(status) && status != ST_IDLE) |-> !int_n);
  p_issue_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_issue |=> !start_issue);
endmodule

// File: tb/tb_i2c_gc_slave_rx.sv
module tb_i2c_gc_slave_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 16;
  localparam int NV = 6;
  // {first byte, data byte, acknowledge enable for data, status after first byte, status after data}
  localparam logic [32:0] VEC [NV] = '{
    {8'h54, 8'hA5, 1'b1, 8'h60, 8'h80},
    {8'h54, 8'h3C, 1'b0, 8'h60, 8'h88},
    {8'h00, 8'h5A, 1'b1, 8'h70, 8'hE0},
    {8'h00, 8'hC3, 1'b0, 8'h70, 8'hE8},
    {8'h55, 8'h00, 1'b1, 8'hF8, 8'hF8},
    {8'h40, 8'h00, 1'b1, 8'hF8, 8'hF8}
  };

  logic clk = 0, rst_n = 0;
  logic host_we = 0, host_sel = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] status, rx_data;
  logic int_n, start_issue, scl_low, sda_low;
  logic bscl = 1, bsda = 1;
  wire scl_line = bscl & ~scl_low;
  wire sda_line = bsda & ~sda_low;
  int checks = 0, fails = 0, pulses = 0;

  i2c_gc_slave_rx dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .status(status), .rx_data(rx_data), .int_n(int_n),
    .start_issue(start_issue), .scl_i(scl_line), .sda_i(sda_line),
    .scl_low(scl_low), .sda_low(sda_low)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (start_issue) pulses++;

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_we = 1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic bus_start;
    bsda = 1; wclk(HALF);
    bscl = 1; while (!scl_line) wclk(1);
    wclk(HALF); bsda = 0; wclk(HALF);
    bscl = 0; wclk(HALF);
  endtask

  task automatic bus_stop;
    bsda = 0; wclk(HALF);
    bscl = 1; while (!scl_line) wclk(1);
    wclk(HALF); bsda = 1; wclk(HALF);
  endtask

  task automatic send_bit(input logic b, output logic s);
    bsda = b; wclk(HALF);
    bscl = 1; while (!scl_line) wclk(1);
    wclk(HALF/2); s = sda_line; wclk(HALF/2);
    bscl = 0; wclk(HALF);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ackd);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(d[i], s);
    send_bit(1'b1, s);
    ackd = ~s;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    logic a, s;
    int p0;
    wclk(3);
    rst_n = 1;
    wclk(2);
    chk("R1 status", status, 8'hF8);
    chk("R1 int_n", {7'b0, int_n}, 8'h01);
    chk("R1 drives", {6'b0, scl_low, sda_low}, 8'h00);
    chk("R1 start_issue", {7'b0, start_issue}, 8'h00);

    host(1, {7'h2A, 1'b1});
    host(0, 8'h04);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] fa, fd, ea, ed;
      logic aad;
      {fa, fd, aad, ea, ed} = VEC[i];
      bus_start;
      send_byte(fa, a);
      chk("R2/R3 address status", status, ea);
      chk("R2/R3 address ack", {7'b0, a}, {7'b0, ea != 8'hF8});
      if (ea != 8'hF8) begin
        host(0, aad ? 8'h04 : 8'h00);
        send_byte(fd, a);
        chk(ea == 8'h70 ? "R5 data status" : "R4 data status", status, ed);
        chk("R4/R5 data ack", {7'b0, a}, {7'b0, aad});
        chk("R4 rx_data", rx_data, fd);
        host(0, 8'h04);
        bus_stop;
        chk(aad ? "R7 stop status" : "R6 stop after nack", status, aad ? 8'hA0 : 8'hF8);
        host(0, 8'h04);
      end else begin
        chk("R2 no irq", {7'b0, int_n}, 8'h01);
        bus_stop;
      end
    end

    // R8: clock hold while the host has not cleared the flag
    bus_start;
    send_byte(8'h54, a);
    chk("R2 own write", status, 8'h60);
    bsda = 1; wclk(HALF);
    bscl = 1; wclk(10);
    chk("R8 scl held", {7'b0, scl_line}, 8'h00);
    chk("R8 irq low", {7'b0, int_n}, 8'h00);
    host(0, 8'h04);
    wclk(6);
    chk("R8 scl released", {7'b0, scl_line}, 8'h01);
    chk("R8 irq high", {7'b0, int_n}, 8'h01);
    chk("R8 status F8", status, 8'hF8);
    wclk(HALF);
    bscl = 0; wclk(HALF);
    for (int i = 6; i >= 0; i--) send_bit(logic'((8'hB3 >> i) & 1), s);
    send_bit(1'b1, s);
    chk("R4 ack after hold", {7'b0, ~s}, 8'h01);
    chk("R4 rx after hold", rx_data, 8'hB3);
    host(0, 8'h04);

    // R7 repeated start, R9 queued start held while busy
    bus_start;
    chk("R7 repeated start", status, 8'hA0);
    chk("R7 no stretch", {7'b0, scl_low}, 8'h00);
    host(0, 8'h24);
    p0 = pulses;
    send_byte(8'h54, a);
    chk("R9 no pulse while busy", pulses[7:0], p0[7:0]);
    host(0, 8'h04);
    bus_stop;
    wclk(4);
    chk("R9 pulse after stop", pulses[7:0], p0[7:0] + 8'd1);
    chk("R7 stop status", status, 8'hA0);
    host(0, 8'h04);

    // R9 idle bus
    p0 = pulses;
    host(0, 8'h24);
    wclk(4);
    chk("R9 pulse on idle bus", pulses[7:0], p0[7:0] + 8'd1);

    // R10 acknowledge enable off
    host(0, 8'h00);
    bus_start;
    send_byte(8'h54, a);
    chk("R10 no ack", {7'b0, a}, 8'h00);
    chk("R10 status", status, 8'hF8);
    bus_stop;
    host(0, 8'h04);

    // R3 general call disabled
    host(1, {7'h2A, 1'b0});
    bus_start;
    send_byte(8'h00, a);
    chk("R3 gc disabled ack", {7'b0, a}, 8'h00);
    chk("R3 gc disabled irq", {7'b0, int_n}, 8'h01);
    bus_stop;
    host(1, {7'h2A, 1'b1});

    // R6 unaddressed after nack
    bus_start;
    send_byte(8'h54, a);
    host(0, 8'h00);
    send_byte(8'h77, a);
    chk("R4 nack status", status, 8'h88);
    host(0, 8'h04);
    send_byte(8'h66, a);
    chk("R6 no ack", {7'b0, a}, 8'h00);
    chk("R6 no irq", {7'b0, int_n}, 8'h01);
    bus_stop;
    chk("R6 stop no status", status, 8'hF8);

    // R11 abort
    bus_start;
    send_byte(8'h54, a);
    host(0, 8'h14);
    send_byte(8'h99, a);
    chk("R11 no ack after abort", {7'b0, a}, 8'h00);
    chk("R11 no irq", {7'b0, int_n}, 8'h01);
    bus_stop;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule